// File: doc/BRIEF.md
# Two-Bus Register File with Shared Read/Write Path

This block is a processor register file with 32 words of 32 bits and two access paths. Path A is a read-only port addressed by its own select. Path B is a single shared data path, addressed by a second select. It carries write data into the array in one phase and read data out of the array in another phase. Because only one B select exists, every write goes through that select. A single register can therefore never receive two writes in the same cycle.

Two control inputs form a two-bit mode code {rd_en, wr_en}. The code picks one of four modes:
- **Idle:** the file leaves path B alone.
- **Write:** a B-path write takes place on the clock edge.
- **Read:** both paths are driven from the array.
- **Both lines high:** a forbidden combination. The block flags it and suppresses both the read and the write.

The bidirectional B bus is split into a `b_in` input, a `b_out` output and a `b_oe` output enable. The surrounding logic forms the tri-state buffer from these three signals. Register 0 is hard-wired to zero. An active-high synchronous reset clears the whole array.

Top module: `regfile_2bus`

## Requirements
- R1: `b_oe` is high only in read mode ({rd_en,wr_en}=2'b10). Whenever `b_oe` is low, `b_out` and `a_data` are all zeros. In idle mode (2'b00), `mode_err` is low and the array contents do not change across clock edges.
- R2: In write mode ({rd_en,wr_en}=2'b01), the rising clock edge stores `b_in` into the register addressed by `sel_b`. A read in any later cycle returns that value.
- R3: In read mode, `a_data` equals the register addressed by `sel_a` and `b_out` equals the register addressed by `sel_b`, in the same cycle, with no clock edge in between.
- R4: When {rd_en,wr_en}=2'b11, `mode_err` is high in that cycle. `b_oe` is low, both outputs are zero, and no register is written on the edge. In every legal mode, `mode_err` is low.
- R5: A write is addressed only by `sel_b`. The value of `sel_a` during a write does not change which register is written.
- R6: On each read path, at most one register is enabled onto the bus. Each register's distinct value appears unmixed when that register is selected.
- R7: Register 0 reads as zero on both paths. Writes to it have no effect.
- R8: With `rst` high on a rising edge, every register is cleared to zero, and reads afterwards return zero until the register is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the array |
| rd_en | input | 1 | Mode bit R: read strobe |
| wr_en | input | 1 | Mode bit W: write strobe |
| sel_a | input | 5 | Register select for path A (read only) |
| sel_b | input | 5 | Register select for path B (read and write) |
| b_in | input | 32 | Value present on the shared B bus, written in write mode |
| a_data | output | 32 | Path A read data, zero outside read mode |
| b_out | output | 32 | Data the file drives onto the B bus in read mode |
| b_oe | output | 1 | B bus drive enable for the external tri-state buffer |
| mode_err | output | 1 | High while the forbidden mode 2'b11 is applied |

## Verification
Read data, `b_oe` and `mode_err` are combinational from the mode, the selects and the stored array, so they are due in the cycle the stimulus is applied. The bench samples them 1 ns after the inputs change on the falling edge, before the next rising edge. A write or reset takes effect on the next rising edge. Its result is therefore checked by a read applied on the following falling edge. A suppressed write in the forbidden mode, or a stable array in idle mode, is shown the same way: a read one edge later must return the old value.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Mode code is {rd_en, wr_en}
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_READ  = 2'b10,
        MODE_BAD   = 2'b11
    } bus_mode_e;

endpackage

// File: rtl/regfile_mode_dec.sv
module regfile_mode_dec
    import regfile_pkg::*;
(
    input  logic      rd_en,
    input  logic      wr_en,
    output bus_mode_e mode,
    output logic      do_read,
    output logic      do_write,
    output logic      bad
);

    always_comb begin
        mode     = bus_mode_e'({rd_en, wr_en});
        do_read  = 1'b0;
        do_write = 1'b0;
        bad      = 1'b0;
        unique case (mode)
            MODE_IDLE:  ;
            MODE_WRITE: do_write = 1'b1;
            MODE_READ:  do_read  = 1'b1;
            MODE_BAD:   bad      = 1'b1;
            default:    bad      = 1'b1;
        endcase
    end

endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               wsel,
    input  logic [WIDTH-1:0]            wdata,
    output logic [NREG-1:0][WIDTH-1:0]  regs
);

    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else if (we && (wsel != '0)) begin
            st_d.regs[wsel] = wdata;
        end
        st_d.regs[0] = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.regs;

endmodule

// File: rtl/regfile_rdmux.sv
module regfile_rdmux #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                        en,
    input  logic [AW-1:0]               sel,
    input  logic [NREG-1:0][WIDTH-1:0]  regs,
    output logic [WIDTH-1:0]            data,
    output logic [NREG-1:0]             hot
);

    // One-hot enable per register; register 0 never drives (reads as zero)
    for (genvar g = 0; g < NREG; g++) begin : g_hot
        if (g == 0) begin : g_zero
            assign hot[g] = 1'b0;
        end else begin : g_sel
            assign hot[g] = en && (sel == AW'(g));
        end
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            data = data | (regs[i] & {WIDTH{hot[i]}});
        end
    end

endmodule

// File: rtl/regfile_2bus.sv
module regfile_2bus
    import regfile_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    sel_a,
    input  logic [AW-1:0]    sel_b,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_data,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             mode_err
);

    bus_mode_e                   mode;
    logic                        do_read;
    logic                        do_write;
    logic                        bad;
    logic [NREG-1:0][WIDTH-1:0]  regs;
    logic [NREG-1:0]             a_hot;
    logic [NREG-1:0]             b_hot;

    regfile_mode_dec u_dec (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .mode     (mode),
        .do_read  (do_read),
        .do_write (do_write),
        .bad      (bad)
    );

    regfile_store #(.NREG(NREG), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write),
        .wsel  (sel_b),
        .wdata (b_in),
        .regs  (regs)
    );

    regfile_rdmux #(.NREG(NREG), .WIDTH(WIDTH)) u_rd_a (
        .en   (do_read),
        .sel  (sel_a),
        .regs (regs),
        .data (a_data),
        .hot  (a_hot)
    );

    regfile_rdmux #(.NREG(NREG), .WIDTH(WIDTH)) u_rd_b (
        .en   (do_read),
        .sel  (sel_b),
        .regs (regs),
        .data (b_out),
        .hot  (b_hot)
    );

    assign b_oe     = (mode == MODE_READ);
    assign mode_err = bad;

endmodule

// File: rtl/regfile_2bus_chk.sv
module regfile_2bus_chk #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input logic [AW-1:0]    sel_a,
    input logic [AW-1:0]    sel_b,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_data,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             mode_err,
    input logic [NREG-1:0]  a_hot,
    input logic [NREG-1:0]  b_hot
);

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !wr_en) |-> (!b_oe && b_out == '0 && a_data == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && sel_b != '0) |=>
        (!(rd_en && !wr_en && sel_a == $past(sel_b)) || a_data == $past(b_in))); // R2

    AST_READ_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |-> (b_oe && !mode_err)); // R3

    AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |-> (mode_err && !b_oe)); // R4

    AST_NO_FALSE_ERR: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en) |-> !mode_err); // R4

    AST_ONE_DRIVER_A: assert property (@(posedge clk) disable iff (rst)
        $onehot0(a_hot)); // R6

    AST_ONE_DRIVER_B: assert property (@(posedge clk) disable iff (rst)
        $onehot0(b_hot)); // R6

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && sel_a == '0) |-> a_data == '0); // R7

    AST_CLEARED_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && $past(rst)) |-> (a_data == '0 && b_out == '0)); // R8

endmodule

bind regfile_2bus regfile_2bus_chk #(.NREG(NREG), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .b_in     (b_in),
    .a_data   (a_data),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .mode_err (mode_err),
    .a_hot    (a_hot),
    .b_hot    (b_hot)
);

// File: tb/tb_regfile_2bus.sv
`timescale 1ns/1ps
module tb_regfile_2bus;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  sel_a = '0;
    logic [4:0]  sel_b = '0;
    logic [31:0] b_in = '0;
    logic [31:0] a_data;
    logic [31:0] b_out;
    logic        b_oe;
    logic        mode_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    regfile_2bus dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .sel_a(sel_a), .sel_b(sel_b), .b_in(b_in),
        .a_data(a_data), .b_out(b_out), .b_oe(b_oe), .mode_err(mode_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i, input logic [7:0] salt);
        return {salt, 8'(i), 8'(~i), 8'(i * 7 + 3)};
    endfunction

    // Apply inputs on the falling edge, let one rising edge pass
    task automatic do_write(input logic [4:0] sb, input logic [31:0] d, input logic [4:0] sa);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; sel_b = sb; sel_a = sa; b_in = d;
        #1;
        chk("R1", "b_oe in write mode", {31'b0, b_oe}, 32'd0);
        chk("R4", "mode_err in write mode", {31'b0, mode_err}, 32'd0);
        @(posedge clk);
        if (sb != 5'd0) model[sb] = d;
        @(negedge clk);
        wr_en = 1'b0; b_in = 32'hDEAD_BEEF;
    endtask

    // Read is combinational: sample 1 ns after applying
    task automatic do_read(input string req, input logic [4:0] sa, input logic [4:0] sb);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b0; sel_a = sa; sel_b = sb;
        #1;
        chk(req, $sformatf("a_data r%0d", sa), a_data, model[sa]);
        chk(req, $sformatf("b_out r%0d", sb), b_out, model[sb]);
        chk("R3", "b_oe in read mode", {31'b0, b_oe}, 32'd1);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "idle b_oe", {31'b0, b_oe}, 32'd0);
        chk("R1", "idle b_out", b_out, 32'd0);
        chk("R1", "idle a_data", a_data, 32'd0);
        chk("R1", "idle mode_err", {31'b0, mode_err}, 32'd0);
        for (int i = 1; i < 32; i += 5) do_read("R8", 5'(i), 5'(31 - i));
    endtask

    task automatic t_write_read_all;
        for (int i = 1; i < 32; i++) do_write(5'(i), pat(i, 8'hC3), 5'(31 - i));
        // R6: every register distinct, each must appear unmixed
        for (int i = 0; i < 32; i++) do_read("R6", 5'(i), 5'((i + 13) % 32));
        do_write(5'd9, 32'hFFFF_FFFF, 5'd0);
        do_write(5'd10, 32'h0000_0000, 5'd0);
        do_read("R2", 5'd9, 5'd10);
        do_read("R3", 5'd10, 5'd9);
    endtask

    task automatic t_sel_a_ignored;
        // R5: sel_a points elsewhere during write; only sel_b target changes
        do_write(5'd4, 32'h1234_5678, 5'd20);
        do_read("R5", 5'd20, 5'd4);
    endtask

    task automatic t_reg0;
        do_write(5'd0, 32'hCAFE_F00D, 5'd0);
        do_read("R7", 5'd0, 5'd0);
        chk("R7", "b_out r0 literal", b_out, 32'd0);
    endtask

    task automatic t_bad_mode;
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; sel_a = 5'd6; sel_b = 5'd6; b_in = 32'h5555_AAAA;
        #1;
        chk("R4", "mode_err", {31'b0, mode_err}, 32'd1);
        chk("R4", "b_oe", {31'b0, b_oe}, 32'd0);
        chk("R4", "b_out", b_out, 32'd0);
        chk("R4", "a_data", a_data, 32'd0);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        #1;
        chk("R4", "mode_err cleared", {31'b0, mode_err}, 32'd0);
        do_read("R4", 5'd6, 5'd6);
    endtask

    task automatic t_idle;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; sel_b = 5'd7; sel_a = 5'd8; b_in = 32'h0BAD_0BAD;
        #1;
        chk("R1", "idle b_oe", {31'b0, b_oe}, 32'd0);
        chk("R1", "idle b_out", b_out, 32'd0);
        chk("R1", "idle a_data", a_data, 32'd0);
        repeat (2) @(posedge clk);
        do_read("R1", 5'd8, 5'd7);
    endtask

    task automatic t_reset_midrun;
        do_write(5'd15, 32'h7777_1111, 5'd0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 32; i++) model[i] = '0;
        @(negedge clk);
        rst = 1'b0;
        do_read("R8", 5'd15, 5'd31);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read_all();
        t_sel_a_ignored();
        t_reg0();
        t_bad_mode();
        t_idle();
        t_reset_midrun();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule